// File: doc/BRIEF.md
# Mailbox Command Handshake Sequencer

This block lets on-chip logic send one command at a time to a remote power-management controller. The two sides share three mailbox registers: a response word, a parameter word and a message word. A client presents a message ID, a 32-bit argument, a formatting mode and a one-cycle start pulse. The sequencer then runs the whole handshake on a simple register read/write master port and reports the outcome once. It first polls the response word until the remote side is no longer busy. It then clears the response, writes the argument and writes the message ID last, which triggers the remote side. It polls the response again, and finally reads the answer back from the parameter word.

Polling is paced by a fixed delay counted in clock cycles, derived from the clock frequency and a delay in microseconds. Each poll phase stops after a bounded number of retries. A response of zero means busy. Any non-zero value ends a poll, and the value 0x01 means success. The argument can be sent unchanged, converted from kHz to MHz with rounding up, or turned into an idle power-down flag word. The answer is also given multiplied by 1000, so that an answer in MHz reads back in kHz.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, error_o and bus_req_o are all 0.
- R2: After a start, the block reads the response word (address 0) and repeats the read while it returns 0. It makes no write until one of these reads returns a non-zero value.
- R3: If the first poll sees RETRY_MAX+1 reads of zero, the command ends with done_o, timeout_o=1, error_o=1 and result_o=0x00. No mailbox write is made.
- R4: Once the mailbox is ready, exactly three writes follow in this order: 0 to the response word (address 0), the formatted argument to the parameter word (address 1), and then the message ID to the message word (address 2).
- R5: After the ID write, the block polls the response word until it reads non-zero. It then reads the parameter word once and ends. result_o holds the low 8 bits of the final response, and param_o holds the word read back.
- R6: Between two successive response reads of one poll phase, there are at least CLK_HZ/1e6*POLL_US clock cycles.
- R7: error_o is 1 on completion exactly when the command timed out or the final response is not 0x01. With a non-OK response, timeout_o stays 0 and param_o still carries the read-back word.
- R8: In mode 1, the parameter word written is ceil(param_i/1000). param_khz_o always equals param_o*1000 (modulo 2^32).
- R9: In mode 2, the parameter word written is 0x3 (bit 0 stops the fabric request path, bit 1 stops the PHY reference clock) when param_i[0] is 1, and 0 otherwise. In mode 0, param_i is written unchanged.
- R10: A start pulse while busy_o is 1 is ignored. The running command's bus traffic and results are unchanged.
- R11: If the second poll sees RETRY_MAX+1 reads of zero, the command ends with timeout_o=1 and error_o=1, and the parameter word is not read.
- R12: busy_o rises in the cycle after an accepted start and falls in the cycle in which done_o is 1. bus_req_o is 1 only while busy_o is 1.
- R13: done_o is a single-cycle pulse per command.
- R14: Once bus_req_o is raised, it stays 1, with the address, direction and write data unchanged, until the cycle in which bus_ack_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| msg_id_i | input | ID_W | Message ID to send |
| param_i | input | DW | Command argument |
| mode_i | input | 2 | Argument format: 0 raw, 1 kHz to MHz ceiling, 2 idle flags, 3 raw |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Final response code, or 0 on timeout |
| param_o | output | DW | Parameter word read back |
| param_khz_o | output | DW | param_o multiplied by 1000 |
| timeout_o | output | 1 | A poll phase ran out of retries |
| error_o | output | 1 | Timeout or non-OK response |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_addr_o | output | 2 | 0 response, 1 parameter, 2 message |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Access complete |

## Verification
The checker watches every cycle for the rules that hold at any moment. It checks that no write comes before a non-zero ready read, that the three writes keep their order and that the clear writes zero. It also checks that requests hold until they are acknowledged, that busy and done relate correctly, that done lasts a single cycle, and that the error flag matches the result code. The bench scenarios cover what depends on a whole command. These are the exact number of poll reads at the retry limit and one past it, the spacing between polls, the kHz rounding and idle flag words, the read-back answer and its kHz scaling, and a start pulse dropped in the middle of a command.

// File: rtl/mbox_cmd_pkg.sv
package mbox_cmd_pkg;

  // mailbox word select on the master port
  localparam logic [1:0] ADDR_RSP = 2'd0;
  localparam logic [1:0] ADDR_PAR = 2'd1;
  localparam logic [1:0] ADDR_MSG = 2'd2;

  // response codes
  localparam logic [7:0] RSP_BUSY      = 8'h00;
  localparam logic [7:0] RSP_OK        = 8'h01;
  localparam logic [7:0] RSP_FAIL      = 8'hFF;
  localparam logic [7:0] RSP_UNKNOWN   = 8'hFE;
  localparam logic [7:0] RSP_NO_PREREQ = 8'hFD;
  localparam logic [7:0] RSP_REJ_BUSY  = 8'hFC;

  // message IDs understood by the remote controller
  localparam logic [7:0] MSG_FW_VERSION   = 8'h02;
  localparam logic [7:0] MSG_DISP_CLK     = 8'h04;
  localparam logic [7:0] MSG_DP_REF_CLK   = 8'h05;
  localparam logic [7:0] MSG_PIPE_CLK     = 8'h06;
  localparam logic [7:0] MSG_FABRIC_MIN   = 8'h07;
  localparam logic [7:0] MSG_SLEEP_MIN    = 8'h08;
  localparam logic [7:0] MSG_FABRIC_QUERY = 8'h0A;
  localparam logic [7:0] MSG_PME_RESTORE  = 8'h0D;
  localparam logic [7:0] MSG_DRAM_HI      = 8'h0E;
  localparam logic [7:0] MSG_DRAM_LO      = 8'h0F;
  localparam logic [7:0] MSG_TBL_OUT      = 8'h10;
  localparam logic [7:0] MSG_TBL_IN       = 8'h11;
  localparam logic [7:0] MSG_IDLE_OPT     = 8'h12;

  typedef enum logic [1:0] {
    CONV_RAW  = 2'd0,
    CONV_KHZ  = 2'd1,
    CONV_IDLE = 2'd2,
    CONV_RSVD = 2'd3
  } conv_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE_RD,
    S_PRE_WAIT,
    S_CLR_WR,
    S_PAR_WR,
    S_MSG_WR,
    S_POST_RD,
    S_POST_WAIT,
    S_ANS_RD
  } seq_state_e;

endpackage

// File: rtl/mbox_unit_conv.sv
module mbox_unit_conv
  import mbox_cmd_pkg::*;
#(
  parameter int DW       = 32,
  parameter int FAB_BIT  = 0,
  parameter int REF_BIT  = 1
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] arg_i,
  output logic [DW-1:0] word_o,
  input  logic [DW-1:0] ans_i,
  output logic [DW-1:0] ans_khz_o
);

  localparam int SW = DW + 1;
  localparam int PW = 2 * DW;

  logic [SW-1:0] khz_sum;
  logic [SW-1:0] mhz_q;
  logic [PW-1:0] khz_prod;
  logic [DW-1:0] idle_word;

  // round up: (kHz + 999) / 1000, widened to keep the carry
  assign khz_sum = {1'b0, arg_i} + SW'(999);
  assign mhz_q   = khz_sum / SW'(1000);

  always_comb begin
    idle_word          = '0;
    idle_word[FAB_BIT] = arg_i[0];
    idle_word[REF_BIT] = arg_i[0];
  end

  always_comb begin
    unique case (conv_mode_e'(mode_i))
      CONV_KHZ:  word_o = mhz_q[DW-1:0];
      CONV_IDLE: word_o = idle_word;
      default:   word_o = arg_i;
    endcase
  end

  assign khz_prod  = {{DW{1'b0}}, ans_i} * PW'(1000);
  assign ans_khz_o = khz_prod[DW-1:0];

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int DELAY_CYC = 1000,
  parameter int RETRY_MAX = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_start_i,
  input  logic retry_clr_i,
  input  logic retry_inc_i,
  output logic expired_o,
  output logic exhausted_o
);

  localparam int DLY   = (DELAY_CYC < 1) ? 1 : DELAY_CYC;
  localparam int DLY_W = $clog2(DLY + 1);
  localparam int RTY_W = $clog2(RETRY_MAX + 2);

  logic [DLY_W-1:0] dly_q;
  logic [RTY_W-1:0] rty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dly_q <= '0;
    else if (wait_start_i) dly_q <= DLY_W'(DLY - 1);
    else if (dly_q != '0)  dly_q <= dly_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rty_q <= '0;
    else if (retry_clr_i) rty_q <= '0;
    else if (retry_inc_i) rty_q <= rty_q + 1'b1;
  end

  assign expired_o   = (dly_q == '0);
  assign exhausted_o = (rty_q == RTY_W'(RETRY_MAX));

endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_cmd_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int POLL_US   = 10,
  parameter int RETRY_MAX = 200000,
  parameter int DW        = 32,
  parameter int ID_W      = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [ID_W-1:0] msg_id_i,
  input  logic [DW-1:0]   param_i,
  input  logic [1:0]      mode_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [7:0]      result_o,
  output logic [DW-1:0]   param_o,
  output logic [DW-1:0]   param_khz_o,
  output logic            timeout_o,
  output logic            error_o,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [1:0]      bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  input  logic            bus_ack_i
);

  localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * POLL_US;

  seq_state_e    state_q;
  logic [ID_W-1:0] msg_q;
  logic [DW-1:0] par_q;
  logic [DW-1:0] ans_q;
  logic [7:0]    res_q;
  logic          done_q, to_q, err_q;

  logic [DW-1:0] fmt_word;
  logic          rsp_nz, is_poll, is_wait;
  logic          wait_start, retry_clr, retry_inc;
  logic          expired, exhausted;

  mbox_unit_conv #(.DW(DW)) u_conv (
    .mode_i    (mode_i),
    .arg_i     (param_i),
    .word_o    (fmt_word),
    .ans_i     (ans_q),
    .ans_khz_o (param_khz_o)
  );

  mbox_poll_timer #(.DELAY_CYC(DELAY_CYC), .RETRY_MAX(RETRY_MAX)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wait_start_i (wait_start),
    .retry_clr_i  (retry_clr),
    .retry_inc_i  (retry_inc),
    .expired_o    (expired),
    .exhausted_o  (exhausted)
  );

  assign rsp_nz  = (bus_rdata_i != '0);
  assign is_poll = (state_q == S_PRE_RD) || (state_q == S_POST_RD);
  assign is_wait = (state_q == S_PRE_WAIT) || (state_q == S_POST_WAIT);

  assign wait_start = is_poll && bus_ack_i && !rsp_nz && !exhausted;
  assign retry_inc  = is_wait && expired;
  assign retry_clr  = ((state_q == S_IDLE) && start_i) ||
                      ((state_q == S_MSG_WR) && bus_ack_i);

  // master port is a pure decode of the state; held until ack
  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b0;
    bus_addr_o  = ADDR_RSP;
    bus_wdata_o = '0;
    unique case (state_q)
      S_PRE_RD, S_POST_RD: ;
      S_CLR_WR: bus_we_o = 1'b1;
      S_PAR_WR: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = ADDR_PAR;
        bus_wdata_o = par_q;
      end
      S_MSG_WR: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = ADDR_MSG;
        bus_wdata_o = DW'(msg_q);
      end
      S_ANS_RD: bus_addr_o = ADDR_PAR;
      default:  bus_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      msg_q   <= '0;
      par_q   <= '0;
      ans_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          msg_q   <= msg_id_i;
          par_q   <= fmt_word;
          ans_q   <= '0;
          res_q   <= '0;
          to_q    <= 1'b0;
          err_q   <= 1'b0;
          state_q <= S_PRE_RD;
        end
        S_PRE_RD: if (bus_ack_i) begin
          if (rsp_nz)         state_q <= S_CLR_WR;
          else if (exhausted) begin
            res_q   <= RSP_BUSY;
            to_q    <= 1'b1;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else            state_q <= S_PRE_WAIT;
        end
        S_PRE_WAIT: if (expired) state_q <= S_PRE_RD;
        S_CLR_WR:   if (bus_ack_i) state_q <= S_PAR_WR;
        S_PAR_WR:   if (bus_ack_i) state_q <= S_MSG_WR;
        S_MSG_WR:   if (bus_ack_i) state_q <= S_POST_RD;
        S_POST_RD: if (bus_ack_i) begin
          if (rsp_nz) begin
            res_q   <= bus_rdata_i[7:0];
            err_q   <= (bus_rdata_i != DW'(RSP_OK));
            state_q <= S_ANS_RD;
          end else if (exhausted) begin
            res_q   <= RSP_BUSY;
            to_q    <= 1'b1;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else   state_q <= S_POST_WAIT;
        end
        S_POST_WAIT: if (expired) state_q <= S_POST_RD;
        S_ANS_RD: if (bus_ack_i) begin
          ans_q   <= bus_rdata_i;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign param_o   = ans_q;
  assign timeout_o = to_q;
  assign error_o   = err_q;

endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk
  import mbox_cmd_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [7:0]    result_o,
  input logic          timeout_o,
  input logic          error_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [1:0]    bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic [DW-1:0] bus_rdata_i,
  input logic          bus_ack_i
);

  logic       ready_seen;
  logic [1:0] wr_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_seen <= 1'b0;
      wr_step    <= '0;
    end else if (start_i && !busy_o) begin
      ready_seen <= 1'b0;
      wr_step    <= '0;
    end else if (bus_req_o && bus_ack_i) begin
      if (!bus_we_o && bus_addr_o == ADDR_RSP && bus_rdata_i != '0 && wr_step == 2'd0)
        ready_seen <= 1'b1;
      if (bus_we_o && wr_step != 2'd3) wr_step <= wr_step + 1'b1;
    end
  end

  assert_no_write_before_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> ready_seen);

  assert_clear_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_RSP |-> wr_step == 2'd0 && bus_wdata_o == '0);

  assert_param_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_PAR |-> wr_step == 2'd1);

  assert_id_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_MSG |-> wr_step == 2'd2);

  assert_timeout_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && timeout_o |-> error_o && result_o == RSP_BUSY);

  assert_ok_no_error_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !timeout_o |-> error_o == (result_o != RSP_OK));

  assert_req_only_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)
                                && $stable(bus_wdata_o));

endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .timeout_o   (timeout_o),
  .error_o     (error_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_rdata_i (bus_rdata_i),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/mbox_cmd_seq_test.sv
module mbox_cmd_seq_test;

  localparam int CLK_HZ = 50_000_000;
  localparam int POLL_US = 1;
  localparam int RETRY = 3;
  localparam int DLY = 50;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] msg_id = '0;
  logic [DW-1:0] param = '0;
  logic [1:0] mode = '0;
  logic busy, done, tmo, err, req, we, ack;
  logic [7:0] result;
  logic [DW-1:0] par_out, par_khz, wdata, rdata;
  logic [1:0] addr;

  always #10 clk = ~clk;

  mbox_cmd_seq #(.CLK_HZ(CLK_HZ), .POLL_US(POLL_US), .RETRY_MAX(RETRY), .DW(DW), .ID_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_id_i(msg_id), .param_i(param),
    .mode_i(mode), .busy_o(busy), .done_o(done), .result_o(result), .param_o(par_out),
    .param_khz_o(par_khz), .timeout_o(tmo), .error_o(err), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ack_i(ack)
  );

  int total = 0, bad = 0, cyc = 0;
  bit hung = 0;

  // remote mailbox model
  logic [DW-1:0] m_rsp = 32'h1, m_par = '0;
  int busy_left = 0;
  logic [DW-1:0] cfg_code = 32'h1, cfg_ans = '0;
  int cfg_post = 0;
  int lg_we[$];
  int lg_addr[$];
  logic [DW-1:0] lg_data[$];
  int lg_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      rdata <= '0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      lg_we.push_back(int'(we));
      lg_addr.push_back(int'(addr));
      lg_data.push_back(wdata);
      lg_cyc.push_back(cyc);
      if (we) begin
        case (addr)
          2'd0: m_rsp <= wdata;
          2'd1: m_par <= wdata;
          2'd2: begin m_rsp <= cfg_code; m_par <= cfg_ans; busy_left <= cfg_post; end
          default: ;
        endcase
      end else begin
        case (addr)
          2'd0: if (busy_left > 0) begin rdata <= '0; busy_left <= busy_left - 1; end
                else rdata <= m_rsp;
          2'd1: rdata <= m_par;
          default: rdata <= '0;
        endcase
      end
    end else ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // per-cycle reference: busy window and done width
  bit exp_busy = 0, prev_done = 0;
  always @(posedge clk) if (rst_n && start && !exp_busy) exp_busy <= 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (done) exp_busy = 1'b0;
    if (busy !== exp_busy) chk(0, "R12", "busy", busy, exp_busy);
    if (req && !busy) chk(0, "R12", "req outside busy", req, 0);
    if (done && prev_done) chk(0, "R13", "done width", 2, 1);
    prev_done = done;
  end

  task automatic run_cmd(input logic [7:0] id, input logic [DW-1:0] p, input logic [1:0] md,
                         input int pre_busy, input int post_busy, input logic [DW-1:0] code,
                         input logic [DW-1:0] ans, input bit overlap, input string rq);
    logic [DW-1:0] pw;
    int n_pre, n_post, k, w;
    bit pre_to, post_to;
    int e_we[$];
    int e_addr[$];
    logic [DW-1:0] e_data[$];
    if (hung) return;
    if (m_rsp == '0) m_rsp = 32'h1;
    busy_left = pre_busy;
    cfg_code = code; cfg_ans = ans; cfg_post = post_busy;
    lg_we.delete(); lg_addr.delete(); lg_data.delete(); lg_cyc.delete();
    @(negedge clk);
    start = 1'b1; msg_id = id; param = p; mode = md;
    @(negedge clk);
    start = 1'b0;
    if (overlap) begin
      repeat (4) @(negedge clk);
      start = 1'b1; msg_id = 8'h55; param = 32'hDEAD_BEEF; mode = 2'd0;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    if (!done) begin hung = 1; chk(0, rq, "watchdog", w, 0); return; end

    case (md)
      2'd1: pw = (p + 32'd999) / 32'd1000;
      2'd2: pw = p[0] ? 32'h3 : 32'h0;
      default: pw = p;
    endcase
    pre_to = pre_busy > RETRY;
    n_pre = pre_to ? RETRY + 1 : pre_busy + 1;
    post_to = (code == '0) || (post_busy > RETRY);
    n_post = post_to ? RETRY + 1 : post_busy + 1;
    for (int i = 0; i < n_pre; i++) begin e_we.push_back(0); e_addr.push_back(0); e_data.push_back('0); end
    if (!pre_to) begin
      e_we.push_back(1); e_addr.push_back(0); e_data.push_back('0);
      e_we.push_back(1); e_addr.push_back(1); e_data.push_back(pw);
      e_we.push_back(1); e_addr.push_back(2); e_data.push_back(DW'(id));
      for (int i = 0; i < n_post; i++) begin e_we.push_back(0); e_addr.push_back(0); e_data.push_back('0); end
      if (!post_to) begin e_we.push_back(0); e_addr.push_back(1); e_data.push_back('0); end
    end

    chk(lg_we.size() == e_we.size(), rq, "access count", lg_we.size(), e_we.size());
    k = (lg_we.size() < e_we.size()) ? lg_we.size() : e_we.size();
    for (int i = 0; i < k; i++) begin
      if (lg_we[i] != e_we[i] || lg_addr[i] != e_addr[i] ||
          (e_we[i] == 1 && lg_data[i] != e_data[i]))
        chk(0, rq, $sformatf("access %0d addr/data", i), {lg_addr[i], lg_data[i]}, {e_addr[i], e_data[i]});
    end
    // R6: spacing of successive response reads in one poll phase
    for (int i = 1; i < k; i++)
      if (lg_we[i] == 0 && lg_addr[i] == 0 && lg_we[i-1] == 0 && lg_addr[i-1] == 0)
        chk(lg_cyc[i] - lg_cyc[i-1] >= DLY, "R6", "poll gap", lg_cyc[i] - lg_cyc[i-1], DLY);

    if (pre_to || post_to) begin
      chk(tmo && err && result == 8'h00, rq, "timeout flags", {tmo, err, result}, {2'b11, 8'h00});
    end else begin
      chk(!tmo, rq, "timeout", tmo, 0);
      chk(err == (code != 32'h1), "R7", "error", err, code != 32'h1);
      chk(result == code[7:0], "R5", "result", result, code[7:0]);
      chk(par_out == ans, "R5", "answer", par_out, ans);
      chk(par_khz == ans * 32'd1000, "R8", "khz scale", par_khz, ans * 32'd1000);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !tmo && !err && !req, "R1", "reset outputs",
        {busy, done, tmo, err, req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cmd(8'h04, 32'h123, 2'd0, 0, 2, 32'h1, 32'h258, 0, "R4");       // R2 R4 R5
    run_cmd(8'h04, 32'd600001, 2'd1, 1, 0, 32'h1, 32'd601, 0, "R8");    // R8 ceiling
    run_cmd(8'h06, 32'd600000, 2'd1, 0, 1, 32'h1, 32'd600, 0, "R8");    // R8 exact
    run_cmd(8'h12, 32'h1, 2'd2, 0, 0, 32'h1, 32'h0, 0, "R9");           // R9 power down
    run_cmd(8'h12, 32'h0, 2'd2, 0, 0, 32'h1, 32'h0, 0, "R9");           // R9 disable
    run_cmd(8'h02, 32'h0, 2'd0, RETRY, 0, 32'h1, 32'h0005_0A00, 0, "R2"); // pre boundary
    run_cmd(8'h07, 32'h77, 2'd0, RETRY + 1, 0, 32'h1, 32'h0, 0, "R3");  // R3 pre timeout
    run_cmd(8'h08, 32'h10, 2'd0, 0, 1, 32'hFD, 32'h44, 0, "R7");        // R7 rejected
    run_cmd(8'h0A, 32'h0, 2'd0, 0, 0, 32'hFF, 32'h9, 0, "R7");          // R7 failed
    run_cmd(8'h05, 32'h20, 2'd0, 0, RETRY, 32'h1, 32'h30, 0, "R5");     // post boundary
    run_cmd(8'h0E, 32'hABCD, 2'd0, 0, 0, 32'h0, 32'h0, 0, "R11");       // R11 post timeout
    run_cmd(8'h10, 32'h3, 2'd0, 2, 1, 32'h1, 32'h11, 1, "R10");         // R10 overlap start
    run_cmd(8'h11, 32'hFFFF_FFFF, 2'd3, 0, 0, 32'h1, 32'h7, 0, "R9");   // R9 raw via mode 3
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule